// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous user port and an external asynchronous static RAM of 131,072 eight-bit words. A user offers one word-sized read or write through a valid/ready handshake. The offer carries a 17-bit address, 8 bits of write data and a write flag. The controller latches the request and drops ready. It then produces the memory-side strobes in a fixed order from a small state machine. For a read, it returns the captured byte with a one-cycle valid pulse.

The memory is selected only while the active-low chip enable is low and the active-high chip enable is high. A write happens only where the write strobe overlaps both selects. Every interval is a clock-cycle count, and each count is at least 1. The read access count and the write pulse count come from nanosecond parameters for a 12 ns speed grade and the clock period. The setup and turnaround counts are given directly.

The data bus is split into an output value, an output enable and an input value, so the pad ring can build the tristate driver. The controller keeps output enable high for the whole of a write. As a result, the write pulse never has to be stretched to cover the memory's output turn-off.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and whenever ready is high, the controller holds the active-low chip enable high, the active-high chip enable low, write enable and output enable high, and the bus drive enable and the response valid low.
- R2: After a read is accepted, the controller keeps the memory selected, output enable low, write enable high, the bus released and the memory address equal to the accepted address for exactly RD_CYC cycles. RD_CYC is 2 at the default 10 ns clock and 12 ns access time.
- R3: Read data is sampled from the bus on the clock edge that ends the read phase. It appears on the response data in the cycle where response valid is high, and response valid is never high for two cycles in a row.
- R4: After a write is accepted, the controller holds a setup phase of WR_SETUP_CYC cycles (1 by default) with the memory selected, write enable high and the write data driven. This is followed by WP_CYC cycles (1 by default) with write enable low. Write enable is low only while both chip enables are active. A later read of the same address returns the written byte.
- R5: The memory address changes only when write enable is high both in that cycle and in the cycle before it.
- R6: The bus drive enable is high through the write setup, the write pulse and one hold cycle after write enable rises, with the write data on the bus. At all other times it is low. It is never high while output enable is low.
- R7: Ready falls in the cycle after a request is accepted. It stays low through a recovery of TURN_CYC cycles (1 by default) with the memory deselected. A read is therefore busy for RD_CYC+TURN_CYC cycles and a write for WR_SETUP_CYC+WP_CYC+TURN_CYC cycles, which is 3 cycles each at the defaults.
- R8: Changes on the request address, data, write flag and valid while ready is low have no effect: the memory address and the bus data stay at the values of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Read data |
| mem_addr_o | output | 17 | Memory address bus |
| mem_dq_o | output | 8 | Value to drive onto the memory data bus |
| mem_dq_oe_o | output | 1 | Drive enable for the memory data bus |
| mem_dq_i | input | 8 | Value seen on the memory data bus |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |

## Verification
The assertions assume that the memory's read data is settled on the bus by the edge that ends the read phase. They also assume that the user changes request fields freely only while ready is low. The bench meets the first assumption with a memory model that updates its read value on the falling clock edge whenever it is selected with output enable low. The model commits a write on the rising edge that ends the write pulse. The driver deliberately scrambles the request address, data, write flag and valid while the controller is busy. This shows that the address stability and data hold properties depend only on the latched request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READ     = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_RECOVER  = 3'd4
  } sram_st_e;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC       = 2,
  parameter int WR_SETUP_CYC = 1,
  parameter int WP_CYC       = 1,
  parameter int TURN_CYC     = 1,
  parameter int CNT_W        = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     start_we_i,
  output sram_st_e state_o,
  output logic     last_o,
  output logic     wr_hold_o
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WS_LD   = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  sram_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = start_we_i ? ST_WR_SETUP : ST_READ;
        cnt_d   = start_we_i ? WS_LD : RD_LD;
      end
      ST_READ: if (last) begin
        state_d = ST_RECOVER;
        cnt_d   = TURN_LD;
      end
      ST_WR_SETUP: if (last) begin
        state_d = ST_WR_PULSE;
        cnt_d   = WP_LD;
      end
      ST_WR_PULSE: if (last) begin
        state_d = ST_RECOVER;
        cnt_d   = TURN_LD;
      end
      ST_RECOVER: if (last) state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      // data hold: one cycle past the end of the write pulse
      hold_q  <= (state_q == ST_WR_PULSE) && last;
    end
  end

  assign state_o   = state_q;
  assign last_o    = last;
  assign wr_hold_o = hold_q;

  // R4
  wr_pulse_follows_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_PULSE) |-> ($past(state_q) inside {ST_WR_SETUP, ST_WR_PULSE}));

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_st_e          state_i,
  input  logic              wr_hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no
);

  logic sel;

  assign sel         = state_i inside {ST_READ, ST_WR_SETUP, ST_WR_PULSE};
  assign mem_ce1_no  = !sel;
  assign mem_ce2_o   = sel;
  // output enable stays high for the whole write: no bus turnaround inside the pulse
  assign mem_oe_no   = (state_i != ST_READ);
  assign mem_we_no   = (state_i != ST_WR_PULSE);
  assign mem_dq_oe_o = (state_i == ST_WR_SETUP) || (state_i == ST_WR_PULSE) || wr_hold_i;
  assign mem_dq_o    = wdata_i;
  assign mem_addr_o  = addr_i;

  // R4
  we_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce1_no && mem_ce2_o && mem_dq_oe_o));

  // R5
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_no && $past(mem_we_no)));

  // R6
  no_contend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));

  // R6
  hold_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && $stable(mem_dq_o)));

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  // R3
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 10,
  parameter int T_RC_NS      = 12,
  parameter int T_WP_NS      = 9,
  parameter int T_DW_NS      = 7,
  parameter int WR_SETUP_CYC = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no
);

  localparam int RD_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
  localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(WR_SETUP_CYC, TURN_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  sram_st_e          state;
  logic              last, wr_hold, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  sram_ctrl_seq #(
    .RD_CYC      (RD_CYC),
    .WR_SETUP_CYC(WR_SETUP_CYC),
    .WP_CYC      (WP_CYC),
    .TURN_CYC    (TURN_CYC),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .start_we_i(req_we_i),
    .state_o   (state),
    .last_o    (last),
    .wr_hold_o (wr_hold)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .wr_hold_i  (wr_hold),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_ce1_no (mem_ce1_no),
    .mem_ce2_o  (mem_ce2_o),
    .mem_oe_no  (mem_oe_no),
    .mem_we_no  (mem_we_no)
  );

  sram_ctrl_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  ((state == ST_READ) && last),
    .dq_i   (mem_dq_i),
    .valid_o(rsp_valid_o),
    .rdata_o(rsp_rdata_o)
  );

  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce1_no && !mem_ce2_o && mem_we_no && mem_oe_no && !mem_dq_oe_o));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R8
  addr_held_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

endmodule

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD_EXP   = 2;
  localparam int WS_EXP   = 1;
  localparam int WP_EXP   = 1;
  localparam int BUSY_EXP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o, mem_dq_i;
  logic          mem_dq_oe, ce1_n, ce2, oe_n, we_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mem_m  [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_q  [$];

  always #5 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_ce1_no(ce1_n), .mem_ce2_o(ce2),
    .mem_oe_no(oe_n), .mem_we_no(we_n)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a) ^ 8'h5A;
  endfunction

  function automatic logic [DW-1:0] model_rd(input int a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction

  // memory model: read value settles by the falling edge, write commits at end of pulse
  always @(negedge clk)
    mem_dq_i <= (!ce1_n && ce2 && !oe_n && we_n) ? model_rd(int'(mem_addr)) : 8'h00;

  always @(posedge clk)
    if (rst_n && !we_n && !ce1_n && ce2 && mem_dq_oe) mem_m[int'(mem_addr)] = mem_dq_o;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", int'(rsp_rdata), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R3 read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy, oecnt, wecnt, setup;
    bit addr_ok, hold_ok, bus_ok;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(int'(a)));
    @(negedge clk);
    // R8: scramble inputs while busy
    req_valid = 1'b1; req_we = ~we; req_addr = ~a; req_wdata = ~d;
    busy = 0; oecnt = 0; wecnt = 0; setup = 0;
    addr_ok = 1; hold_ok = 1; bus_ok = 1;
    while (!req_ready && busy < 20) begin
      busy++;
      if (!oe_n) begin
        oecnt++;
        if (mem_addr != a || mem_dq_oe || ce1_n || !ce2 || !we_n) addr_ok = 0;
      end
      if (we && !ce1_n && ce2 && we_n && wecnt == 0) begin
        setup++;
        if (!mem_dq_oe || mem_dq_o != d) bus_ok = 0;
      end
      if (!we_n) begin
        wecnt++;
        if (mem_addr != a || mem_dq_o != d || !mem_dq_oe) addr_ok = 0;
      end
      if (ce1_n && we) begin
        if (busy == WS_EXP + WP_EXP + 1) begin
          if (!mem_dq_oe || mem_dq_o != d) hold_ok = 0;
        end else if (mem_dq_oe) hold_ok = 0;
      end
      if (!we && mem_dq_oe) bus_ok = 0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(busy == BUSY_EXP, "R7 busy cycles", busy, BUSY_EXP);
    check(addr_ok, "R8 address/data held from accepted request", int'(mem_addr), int'(a));
    if (we) begin
      check(setup == WS_EXP, "R4 write setup cycles", setup, WS_EXP);
      check(wecnt == WP_EXP, "R4 write pulse cycles", wecnt, WP_EXP);
      check(bus_ok, "R6 data driven in setup", int'(mem_dq_o), int'(d));
      check(hold_ok, "R6 hold cycle then release", int'(mem_dq_oe), 0);
      check(oecnt == 0, "R6 output enable stays high in write", oecnt, 0);
    end else begin
      check(oecnt == RD_EXP, "R2 read phase cycles", oecnt, RD_EXP);
      check(wecnt == 0, "R2 write enable high in read", wecnt, 0);
      check(bus_ok, "R6 bus released during read", int'(mem_dq_oe), 0);
    end
    // R1 idle pins after the access
    check(ce1_n && !ce2 && we_n && oe_n && !mem_dq_oe, "R1 idle pins",
          int'({ce1_n, ce2, we_n, oe_n, mem_dq_oe}), 5'b10110);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check(ce1_n && !ce2 && we_n && oe_n && !mem_dq_oe && !rsp_valid, "R1 reset pins",
          int'({ce1_n, ce2, we_n, oe_n, mem_dq_oe, rsp_valid}), 6'b101100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);

    access(1'b1, 17'h00000, 8'hA5);
    access(1'b1, 17'h1FFFF, 8'hFF);
    access(1'b1, 17'h0ABCD, 8'h00);
    access(1'b0, 17'h00000, 8'h00);   // R3 boundary low
    access(1'b0, 17'h1FFFF, 8'h00);   // R3 boundary high
    access(1'b0, 17'h0ABCD, 8'h00);
    access(1'b0, 17'h12345, 8'h00);   // never written
    access(1'b1, 17'h00010, 8'h3C);
    access(1'b0, 17'h00010, 8'h00);   // R4 read-back right after write
    access(1'b1, 17'h00010, 8'hC3);
    access(1'b1, 17'h00011, 8'h81);
    access(1'b0, 17'h00010, 8'h00);
    access(1'b0, 17'h00011, 8'h00);
    for (int i = 0; i < 16; i++) access(1'b1, AW'(i * 4099), DW'(i * 37 + 1));
    for (int i = 15; i >= 0; i--) access(1'b0, AW'(i * 4099), 8'h00);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule